// File: doc/BRIEF.md
# CAN Error Confinement and Bus-Off Recovery Unit

This unit holds the transmit and receive error counters of a CAN node and turns them into two fault-confinement indications: an early-warning flag and a bus-off flag. Error and success pulses from the protocol engine move the counters up or down. When a transmit error would push the transmit counter past its ceiling, the node goes bus-off. It also forces itself into initialization mode, and from then on it ignores all further bus events.

Leaving bus-off is under software control. The node stays bus-off until the CPU clears the init bit. The unit then watches the sampled bus level on each bit strobe and counts runs of 11 consecutive recessive bits. Each completed run raises a sticky recovery flag and a one-cycle status event. After 128 runs, both counters return to zero and bus-off drops, and the node resumes normal operation. Init writes made during recovery cannot cut the sequence short.

Top module: `can_err_confine`

## Requirements
- R1: `warn` is 1 in the cycle after either counter reaches 96 or more, and returns to 0 once both counters are below 96.
- R2: While the node is active (not bus-off, `init` = 0), `tx_err` adds 8 to `tec`. If the sum would exceed 255, `tec` becomes 255 and `bus_off` rises one cycle later.
- R3: Entering bus-off sets `init` to 1 in the same cycle. While `bus_off` = 1 or `init` = 1, all error and success pulses leave `tec` and `rec` unchanged.
- R4: While the node is active, `rx_err` adds 1 to `rec`, saturating at 255. `tx_ok` and `rx_ok` each subtract 1 from their own counter, with a floor of 0. An error pulse takes precedence over a success pulse on the same counter in the same cycle.
- R5: Recovery begins only when `init_clr` arrives while the node is bus-off; that write also drives `init` to 0. Bit strobes seen before that write are not counted. Outside bus-off, `init_clr` only clears `init`, and `init_set` sets it, with set taking precedence.
- R6: During recovery, a strobe with `bit_recessive` = 1 that completes 11 consecutive recessive strobes causes two things in the next cycle: `status_evt` pulses high for one cycle, and `recov_flag` becomes 1.
- R7: During recovery, a strobe with `bit_recessive` = 0 restarts the current run count at zero.
- R8: During recovery, `init_set` and `init_clr` have no effect. `init` stays 0, and the number of runs needed stays 128.
- R9: In the cycle the 128th run's `status_evt` appears, the following values all appear together: `tec` = 0, `rec` = 0, `warn` = 0, `bus_off` = 0 and `init` = 0. The node is active again from that cycle on.
- R10: `flag_ack` clears `recov_flag`. A run completing in the same cycle as `flag_ack` keeps the flag at 1.
- R11: After reset: `tec` = 0, `rec` = 0, `warn` = 0, `bus_off` = 0, `init` = 1, `recov_flag` = 0, `status_evt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_strobe | input | 1 | One-cycle pulse marking a bus bit sample |
| bit_recessive | input | 1 | Sampled bus level at the strobe (1 = recessive) |
| tx_err | input | 1 | Transmit error event pulse |
| rx_err | input | 1 | Receive error event pulse |
| tx_ok | input | 1 | Successful transmit pulse |
| rx_ok | input | 1 | Successful receive pulse |
| init_set | input | 1 | CPU write setting the init bit |
| init_clr | input | 1 | CPU write clearing the init bit |
| flag_ack | input | 1 | CPU acknowledge clearing the recovery flag |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| warn | output | 1 | Error warning flag |
| bus_off | output | 1 | Bus-off flag |
| init | output | 1 | Init bit (node disconnected from bus activity) |
| recov_flag | output | 1 | Sticky flag set by each completed recessive run |
| status_evt | output | 1 | One-cycle status event per completed recessive run |

## Verification
The counters and every flag are registered ports, so a fault in a counter or in the operating state appears at `tec`, `rec`, `warn` or `bus_off` one cycle after the pulse that caused it. A fault in the recessive-run counter or in the sequence counter stays hidden inside recovery. It becomes visible as a misplaced or missing `status_evt` pulse, and as a `bus_off` release that comes early or late. Either shows up within 11 strobes, and at the latest at the end of the 128-run sequence. The bench steps a cycle model alongside the design and compares every output after every clock. It combines directed bus-off and recovery sequences with random event traffic that crosses bus-off several times.

// File: rtl/can_ec_pkg.sv
package can_ec_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_BUSOFF  = 2'd1,
        ST_RECOVER = 2'd2
    } ec_state_e;

    typedef struct packed {
        ec_state_e state;
        logic      init;
        logic      bus_off;
        logic      flag;
        logic      evt;
    } ec_ctrl_t;

endpackage

// File: rtl/can_ec_counters.sv
module can_ec_counters #(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int TX_STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             clear_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    output logic             trip_o,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic             warn_o
);
    localparam logic [CNT_W:0]   SUM_MAX = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WARN_V  = CNT_W'(WARN_LVL);
    localparam logic [CNT_W:0]   STEP_V  = (CNT_W+1)'(TX_STEP);

    typedef struct packed {
        logic [CNT_W-1:0] tec;
        logic [CNT_W-1:0] rec;
        logic             warn;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [CNT_W:0] tec_sum;

    always_comb begin
        tec_sum = {1'b0, cnt_q.tec} + STEP_V;
        trip_o  = active_i && tx_err_i && (tec_sum > SUM_MAX);
        cnt_d   = cnt_q;
        if (clear_i) begin
            cnt_d.tec = '0;
            cnt_d.rec = '0;
        end else if (active_i) begin
            if (tx_err_i) begin
                cnt_d.tec = trip_o ? CNT_MAX : tec_sum[CNT_W-1:0];
            end else if (tx_ok_i && cnt_q.tec != '0) begin
                cnt_d.tec = cnt_q.tec - 1'b1;
            end
            if (rx_err_i) begin
                if (cnt_q.rec != CNT_MAX) cnt_d.rec = cnt_q.rec + 1'b1;
            end else if (rx_ok_i && cnt_q.rec != '0) begin
                cnt_d.rec = cnt_q.rec - 1'b1;
            end
        end
        cnt_d.warn = (cnt_d.tec >= WARN_V) || (cnt_d.rec >= WARN_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tec_o  = cnt_q.tec;
    assign rec_o  = cnt_q.rec;
    assign warn_o = cnt_q.warn;

    p_warn_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.tec >= WARN_V || cnt_q.rec >= WARN_V) |-> warn_o);

    p_inactive_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !clear_i) |=> ($stable(tec_o) && $stable(rec_o)));

    p_tec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_err_i && !tx_ok_i && !clear_i) |=> $stable(tec_o));

    p_tec_no_rise_on_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_err_i && !clear_i) |=> (tec_o <= $past(tec_o)));

endmodule

// File: rtl/can_ec_recovery.sv
module can_ec_recovery #(
    parameter int RUN_LEN = 11,
    parameter int SEQ_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic strobe_i,
    input  logic level_i,
    output logic run_done_o,
    output logic seq_done_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int SEQ_W = $clog2(SEQ_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [SEQ_W-1:0] seq;
    } rcv_t;

    rcv_t rcv_d, rcv_q;

    always_comb begin
        rcv_d      = rcv_q;
        run_done_o = 1'b0;
        seq_done_o = 1'b0;
        if (!en_i) begin
            rcv_d = '0;
        end else if (strobe_i) begin
            if (!level_i) begin
                rcv_d.run = '0;
            end else if (rcv_q.run == RUN_LAST) begin
                run_done_o = 1'b1;
                rcv_d.run  = '0;
                if (rcv_q.seq == SEQ_LAST) begin
                    seq_done_o = 1'b1;
                    rcv_d.seq  = '0;
                end else begin
                    rcv_d.seq = rcv_q.seq + 1'b1;
                end
            end else begin
                rcv_d.run = rcv_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rcv_q <= '0;
        else        rcv_q <= rcv_d;
    end

    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_q.run <= RUN_LAST);

    p_dominant_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && strobe_i && !level_i) |=> (rcv_q.run == '0));

    p_seq_only_on_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !run_done_o) |=> $stable(rcv_q.seq));

endmodule

// File: rtl/can_err_confine.sv
module can_err_confine
    import can_ec_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int TX_STEP  = 8,
    parameter int RUN_LEN  = 11,
    parameter int SEQ_LEN  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             bit_recessive,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             init_set,
    input  logic             init_clr,
    input  logic             flag_ack,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic             warn,
    output logic             bus_off,
    output logic             init,
    output logic             recov_flag,
    output logic             status_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam ec_ctrl_t CTRL_RST = '{state: ST_ACTIVE, init: 1'b1,
                                      bus_off: 1'b0, flag: 1'b0, evt: 1'b0};

    ec_ctrl_t ctl_d, ctl_q;
    logic active, trip, run_done, seq_done, rcv_en;

    assign active = (ctl_q.state == ST_ACTIVE) && !ctl_q.init;
    assign rcv_en = (ctl_q.state == ST_RECOVER);

    can_ec_counters #(
        .CNT_W   (CNT_W),
        .WARN_LVL(WARN_LVL),
        .TX_STEP (TX_STEP)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .clear_i (seq_done),
        .tx_err_i(tx_err),
        .tx_ok_i (tx_ok),
        .rx_err_i(rx_err),
        .rx_ok_i (rx_ok),
        .trip_o  (trip),
        .tec_o   (tec),
        .rec_o   (rec),
        .warn_o  (warn)
    );

    can_ec_recovery #(
        .RUN_LEN(RUN_LEN),
        .SEQ_LEN(SEQ_LEN)
    ) u_rcv (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rcv_en),
        .strobe_i  (bit_strobe),
        .level_i   (bit_recessive),
        .run_done_o(run_done),
        .seq_done_o(seq_done)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.evt = run_done;
        if (run_done)      ctl_d.flag = 1'b1;
        else if (flag_ack) ctl_d.flag = 1'b0;
        unique case (ctl_q.state)
            ST_ACTIVE: begin
                if (trip) begin
                    ctl_d.state   = ST_BUSOFF;
                    ctl_d.bus_off = 1'b1;
                    ctl_d.init    = 1'b1;
                end else if (init_set) begin
                    ctl_d.init = 1'b1;
                end else if (init_clr) begin
                    ctl_d.init = 1'b0;
                end
            end
            ST_BUSOFF: begin
                if (init_clr) begin
                    ctl_d.state = ST_RECOVER;
                    ctl_d.init  = 1'b0;
                end
            end
            ST_RECOVER: begin
                if (seq_done) begin
                    ctl_d.state   = ST_ACTIVE;
                    ctl_d.bus_off = 1'b0;
                end
            end
            default: ctl_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTRL_RST;
        else        ctl_q <= ctl_d;
    end

    assign bus_off    = ctl_q.bus_off;
    assign init       = ctl_q.init;
    assign recov_flag = ctl_q.flag;
    assign status_evt = ctl_q.evt;

    p_busoff_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |-> (tec == CNT_MAX));

    p_busoff_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_BUSOFF) |-> (init && bus_off));

    p_evt_in_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_evt |-> ($past(ctl_q.state) == ST_RECOVER));

    p_evt_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_evt |-> recov_flag);

    p_init_low_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_RECOVER) |-> !init);

    p_release_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_off) |-> (tec == '0 && rec == '0 && !warn && !init));

endmodule

// File: tb/tb_can_err_confine.sv
module tb_can_err_confine;
    localparam int CLK_NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_strobe = 0, bit_recessive = 1, tx_err = 0, rx_err = 0;
    logic tx_ok = 0, rx_ok = 0, init_set = 0, init_clr = 0, flag_ack = 0;
    logic [7:0] tec, rec;
    logic warn, bus_off, init, recov_flag, status_evt;

    int n_chk = 0;
    int n_fail = 0;
    int n_evt = 0;
    bit done = 0;

    // reference model state: 0 active, 1 bus-off, 2 recovering
    int m_st, m_init, m_tec, m_rec, m_bo, m_warn, m_run, m_seq, m_flag, m_evt;

    always #(CLK_NS/2) clk = ~clk;

    can_err_confine dut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_recessive(bit_recessive),
        .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .init_set(init_set), .init_clr(init_clr), .flag_ack(flag_ack),
        .tec(tec), .rec(rec), .warn(warn), .bus_off(bus_off), .init(init),
        .recov_flag(recov_flag), .status_evt(status_evt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int dec0(input int v);
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic model_reset();
        m_st = 0; m_init = 1; m_tec = 0; m_rec = 0; m_bo = 0; m_warn = 0;
        m_run = 0; m_seq = 0; m_flag = 0; m_evt = 0;
    endtask

    task automatic model_step();
        int act, trip, rdone, sdone;
        act = (m_st == 0 && m_init == 0) ? 1 : 0;
        trip = (act != 0 && tx_err && m_tec + 8 > 255) ? 1 : 0;
        rdone = 0; sdone = 0;
        if (m_st == 2 && bit_strobe) begin
            if (!bit_recessive) m_run = 0;
            else if (m_run == 10) begin
                m_run = 0; rdone = 1;
                if (m_seq == 127) begin sdone = 1; m_seq = 0; end
                else m_seq++;
            end else m_run++;
        end else if (m_st != 2) begin
            m_run = 0; m_seq = 0;
        end
        if (sdone != 0) begin
            m_tec = 0; m_rec = 0;
        end else if (act != 0) begin
            if (tx_err) m_tec = (trip != 0) ? 255 : m_tec + 8;
            else if (tx_ok) m_tec = dec0(m_tec);
            if (rx_err) m_rec = (m_rec < 255) ? m_rec + 1 : 255;
            else if (rx_ok) m_rec = dec0(m_rec);
        end
        m_warn = (m_tec >= 96 || m_rec >= 96) ? 1 : 0;
        m_evt = rdone;
        if (rdone != 0) m_flag = 1;
        else if (flag_ack) m_flag = 0;
        case (m_st)
            0: if (trip != 0) begin m_st = 1; m_bo = 1; m_init = 1; end
               else if (init_set) m_init = 1;
               else if (init_clr) m_init = 0;
            1: if (init_clr) begin m_st = 2; m_init = 0; end
            default: if (sdone != 0) begin m_st = 0; m_bo = 0; end
        endcase
    endtask

    task automatic compare_all();
        chk("R2", "tec", int'(tec), m_tec);
        chk("R4", "rec", int'(rec), m_rec);
        chk("R1", "warn", int'(warn), m_warn);
        chk("R3", "bus_off", int'(bus_off), m_bo);
        chk("R8", "init", int'(init), m_init);
        chk("R10", "recov_flag", int'(recov_flag), m_flag);
        chk("R6", "status_evt", int'(status_evt), m_evt);
        if (status_evt) n_evt++;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        {bit_strobe, tx_err, rx_err, tx_ok, rx_ok, init_set, init_clr, flag_ack} = '0;
        bit_recessive = 1'b1;
    endtask

    task automatic strobes(input int n, input bit lvl);
        for (int i = 0; i < n; i++) begin
            bit_strobe = 1'b1; bit_recessive = lvl; tick();
        end
    endtask

    task automatic force_busoff();
        while (!bus_off) begin tx_err = 1'b1; tick(); end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "reset tec", int'(tec), 0);
        chk("R11", "reset rec", int'(rec), 0);
        chk("R11", "reset init", int'(init), 1);
        chk("R11", "reset flags", int'({warn, bus_off, recov_flag, status_evt}), 0);

        // R3: events ignored while init = 1
        tx_err = 1; rx_err = 1; tick();
        chk("R3", "tec frozen while init", int'(tec), 0);
        init_clr = 1; tick();
        // R1/R2: warning at 96
        repeat (12) begin tx_err = 1; tick(); end
        chk("R1", "warn at tec 96", int'(warn), 1);
        tx_ok = 1; tick();
        chk("R1", "warn clears at 95", int'(warn), 0);
        // R4: error wins over success on same counter
        tx_err = 1; tx_ok = 1; rx_err = 1; rx_ok = 1; tick();
        chk("R4", "tx_err wins", int'(tec), 103);
        chk("R4", "rx_err wins", int'(rec), 1);
        repeat (3) begin rx_ok = 1; tick(); end
        chk("R4", "rec floor 0", int'(rec), 0);
        // R5: init_set outside bus-off, set wins
        init_set = 1; init_clr = 1; tick();
        chk("R5", "set wins", int'(init), 1);
        init_clr = 1; tick();
        // R2/R3: bus-off
        force_busoff();
        chk("R2", "tec saturated", int'(tec), 255);
        chk("R3", "init forced", int'(init), 1);
        // R5: strobes before init_clr are not counted
        strobes(30, 1'b1);
        chk("R5", "no events before clear", n_evt, 0);
        init_clr = 1; tick();
        // R7: dominant restarts the run
        strobes(10, 1'b1);
        strobes(1, 1'b0);
        strobes(10, 1'b1);
        chk("R7", "no run after restart", n_evt, 0);
        strobes(1, 1'b1);
        chk("R6", "first run event", n_evt, 1);
        // R10: ack clears, coincident set wins
        flag_ack = 1; tick();
        chk("R10", "ack clears", int'(recov_flag), 0);
        strobes(10, 1'b1);
        bit_strobe = 1; flag_ack = 1; tick();
        chk("R10", "set beats ack", int'(recov_flag), 1);
        // R8: init writes during recovery ignored
        for (int r = 2; r < 127; r++) begin
            if (r % 16 == 0) begin init_set = 1; tick(); end
            if (r % 16 == 5) begin init_clr = 1; tick(); end
            strobes(11, 1'b1);
        end
        chk("R8", "still bus-off before last run", int'(bus_off), 1);
        strobes(11, 1'b1);
        chk("R9", "released after 128 runs", int'({bus_off, init, warn}), 0);
        chk("R9", "counters cleared", int'(tec) + int'(rec), 0);
        chk("R9", "event count", n_evt, 128);

        // random traffic crossing bus-off several times
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 20000; i++) begin
            bit_strobe    = ($urandom % 100) < 75;
            bit_recessive = ($urandom % 100) < 97;
            tx_err   = ($urandom % 100) < 22;
            tx_ok    = ($urandom % 100) < 30;
            rx_err   = ($urandom % 100) < 40;
            rx_ok    = ($urandom % 100) < 35;
            init_set = ($urandom % 100) < 2;
            init_clr = ($urandom % 100) < 12;
            flag_ack = ($urandom % 100) < 10;
            tick();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule